// File: doc/BRIEF.md
# Early-Exit Unsigned Greater-Than Comparator

This block registers two unsigned operands and reports, one clock after capture, whether the first is strictly greater than the second. The top bit of each operand is always captured and compared on its own. When those top bits differ, they alone decide the answer. In that case the registers holding the remaining lower bits are not reloaded, so the wide comparator behind them sees no input change and its switching activity drops.

The lower-bit registers take new data only when the incoming top bits match. Only in that case does the wide comparator decide the result. A free-running counter reports how many cycles skipped the lower-bit load, which gives a direct measure of how often the wide path was frozen. The load enable is a synchronous enable and not a gated clock.

Top module: `precomp_gt`

## Requirements
- R1: `a_gt_b` is 1 exactly when `a_in` > `b_in` as unsigned numbers. The pair applied before rising edge k is captured at edge k, and the result appears after edge k+1.
- R2: The top bit (index WIDTH-1) of each operand is captured on every rising edge that is out of reset, whatever the other bits hold.
- R3: When the captured top bits differ, the result equals the captured top bit of `a_in`. The lower bits have no effect on it.
- R4: When the captured top bits are equal, the result is the unsigned greater-than of the most recently loaded lower bits (indices WIDTH-2 down to 0).
- R5: The lower-bit registers load on an edge only when the incoming top bits of `a_in` and `b_in` are equal. On any other edge they hold their value.
- R6: `skip_count` rises by one, wrapping at 2^CNT_W, on every non-reset edge where the lower-bit load was skipped. It holds on every other non-reset edge.
- R7: A synchronous active-high `rst` clears all operand registers, `a_gt_b` and `skip_count` on the next rising edge. While `rst` is high, `skip_count` stays 0 whatever the inputs are.
- R8: The operand width WIDTH is a parameter (default 8, minimum 2), and R1 to R6 hold at WIDTH = 2, where the lower part is a single bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| a_in | input | WIDTH | First unsigned operand |
| b_in | input | WIDTH | Second unsigned operand |
| a_gt_b | output | 1 | Registered result: a_in greater than b_in |
| skip_count | output | CNT_W | Number of cycles in which the lower-bit load was skipped |

## Verification
The bench builds two copies of the block side by side. One uses the default width of 8, which allows mixed patterns where the top bits alone decide and patterns where the lower bits break a tie. The other uses the minimum width of 2, where every operand pair can be applied exhaustively and the lower comparator shrinks to a single bit. With both widths, the switch between early exit and full compare is tested at its smallest and at a typical size, including reset while the top bits differ.

// File: rtl/cmp_pkg.sv
package cmp_pkg;

    localparam int DEF_WIDTH = 8;
    localparam int DEF_CNT_W = 16;

    // Which comparator path settles the result this cycle.
    typedef enum logic {
        DECIDE_MSB = 1'b0,
        DECIDE_LOW = 1'b1
    } decide_e;

    // Captured top bits of both operands.
    typedef struct packed {
        logic a;
        logic b;
    } msb_pair_t;

    // Greater-than from a single pair of top bits.
    function automatic logic msb_gt(input msb_pair_t p);
        return p.a & ~p.b;
    endfunction

    // Top bits disagree: the early path decides.
    function automatic decide_e pick_path(input msb_pair_t p);
        return (p.a ^ p.b) ? DECIDE_MSB : DECIDE_LOW;
    endfunction

endpackage

// File: rtl/pc_enable_gen.sv
module pc_enable_gen (
    input  logic msb_a,
    input  logic msb_b,
    output logic load_en
);
    // Lower bits are only needed when the top bits tie.
    always_comb begin
        load_en = ~(msb_a ^ msb_b);
    end
endmodule

// File: rtl/pc_operand_regs.sv
module pc_operand_regs #(
    parameter int WIDTH = cmp_pkg::DEF_WIDTH
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  load_en,
    input  logic [WIDTH-1:0]      a_in,
    input  logic [WIDTH-1:0]      b_in,
    output cmp_pkg::msb_pair_t    msb_q,
    output logic [WIDTH-2:0]      low_a_q,
    output logic [WIDTH-2:0]      low_b_q
);
    localparam int MSB   = WIDTH - 1;
    localparam int LOW_W = WIDTH - 1;

    // Top bits: loaded every cycle.
    always_ff @(posedge clk) begin
        if (rst) begin
            msb_q <= '0;
        end else begin
            msb_q.a <= a_in[MSB];
            msb_q.b <= b_in[MSB];
        end
    end

    // Lower bits: loaded only under the precomputed enable.
    always_ff @(posedge clk) begin
        if (rst) begin
            low_a_q <= '0;
            low_b_q <= '0;
        end else if (load_en) begin
            low_a_q <= a_in[LOW_W-1:0];
            low_b_q <= b_in[LOW_W-1:0];
        end
    end
endmodule

// File: rtl/pc_low_compare.sv
module pc_low_compare #(
    parameter int W = cmp_pkg::DEF_WIDTH - 1
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic         gt
);
    // Ripple from the least significant bit upward; a higher bit overrides.
    logic [W:0] chain;
    assign chain[0] = 1'b0;

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign chain[i+1] = (a[i] & ~b[i]) | (~(a[i] ^ b[i]) & chain[i]);
    end

    assign gt = chain[W];
endmodule

// File: rtl/precomp_gt.sv
module precomp_gt #(
    parameter int WIDTH = cmp_pkg::DEF_WIDTH,
    parameter int CNT_W = cmp_pkg::DEF_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] a_in,
    input  logic [WIDTH-1:0] b_in,
    output logic             a_gt_b,
    output logic [CNT_W-1:0] skip_count
);
    import cmp_pkg::*;

    localparam int MSB   = WIDTH - 1;
    localparam int LOW_W = WIDTH - 1;

    logic              load_en;
    msb_pair_t         msb_q;
    logic              msb_a_q;
    logic              msb_b_q;
    logic [LOW_W-1:0]  low_a_q;
    logic [LOW_W-1:0]  low_b_q;
    logic              low_gt;
    decide_e           path;
    logic              f_next;

    pc_enable_gen u_en (
        .msb_a   (a_in[MSB]),
        .msb_b   (b_in[MSB]),
        .load_en (load_en)
    );

    pc_operand_regs #(.WIDTH(WIDTH)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .load_en (load_en),
        .a_in    (a_in),
        .b_in    (b_in),
        .msb_q   (msb_q),
        .low_a_q (low_a_q),
        .low_b_q (low_b_q)
    );

    pc_low_compare #(.W(LOW_W)) u_low (
        .a  (low_a_q),
        .b  (low_b_q),
        .gt (low_gt)
    );

    assign msb_a_q = msb_q.a;
    assign msb_b_q = msb_q.b;

    always_comb begin
        path = pick_path(msb_q);
        unique case (path)
            DECIDE_MSB: f_next = msb_gt(msb_q);
            DECIDE_LOW: f_next = low_gt;
            default:    f_next = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            a_gt_b <= 1'b0;
        end else begin
            a_gt_b <= f_next;
        end
    end

    // Activity monitor: cycles whose lower-bit load was skipped.
    always_ff @(posedge clk) begin
        if (rst) begin
            skip_count <= '0;
        end else if (!load_en) begin
            skip_count <= skip_count + 1'b1;
        end
    end
endmodule

// File: rtl/pc_checker.sv
module pc_checker #(
    parameter int WIDTH = cmp_pkg::DEF_WIDTH,
    parameter int CNT_W = cmp_pkg::DEF_CNT_W
) (
    input logic             clk,
    input logic             rst,
    input logic [WIDTH-1:0] a_in,
    input logic [WIDTH-1:0] b_in,
    input logic             load_en,
    input logic             msb_a_q,
    input logic             msb_b_q,
    input logic [WIDTH-2:0] low_a_q,
    input logic [WIDTH-2:0] low_b_q,
    input logic             a_gt_b,
    input logic [CNT_W-1:0] skip_count
);
    localparam int MSB   = WIDTH - 1;
    localparam int LOW_W = WIDTH - 1;

    logic [CNT_W-1:0] cnt_plus;
    assign cnt_plus = skip_count + 1'b1;

    // R1: end-to-end result against the operands two edges back
    p_result_r1: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(rst, 2)) |-> (a_gt_b == ($past(a_in, 2) > $past(b_in, 2))));

    // R2: top bits follow the inputs every cycle
    p_msb_capture_r2: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (msb_a_q == $past(a_in[MSB]) && msb_b_q == $past(b_in[MSB])));

    // R3: differing top bits decide alone
    p_msb_decides_r3: assert property (@(posedge clk) disable iff (rst)
        (msb_a_q != msb_b_q) |=> (a_gt_b == $past(msb_a_q)));

    // R4: tied top bits defer to the lower bits
    p_low_decides_r4: assert property (@(posedge clk) disable iff (rst)
        (msb_a_q == msb_b_q) |=> (a_gt_b == ($past(low_a_q) > $past(low_b_q))));

    // R5: load when enabled, hold otherwise
    p_low_load_r5: assert property (@(posedge clk) disable iff (rst)
        load_en |=> (low_a_q == $past(a_in[LOW_W-1:0]) && low_b_q == $past(b_in[LOW_W-1:0])));

    p_low_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !load_en |=> ($stable(low_a_q) && $stable(low_b_q)));

    // R6: counter steps on skipped loads only
    p_cnt_step_r6: assert property (@(posedge clk) disable iff (rst)
        !load_en |=> (skip_count == $past(cnt_plus)));

    p_cnt_hold_r6: assert property (@(posedge clk) disable iff (rst)
        load_en |=> $stable(skip_count));

    // R7: reset clears result and counter
    p_reset_r7: assert property (@(posedge clk)
        rst |=> (a_gt_b == 1'b0 && skip_count == '0));
endmodule

bind precomp_gt pc_checker #(.WIDTH(WIDTH), .CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .a_in       (a_in),
    .b_in       (b_in),
    .load_en    (load_en),
    .msb_a_q    (msb_a_q),
    .msb_b_q    (msb_b_q),
    .low_a_q    (low_a_q),
    .low_b_q    (low_b_q),
    .a_gt_b     (a_gt_b),
    .skip_count (skip_count)
);

// File: tb/precomp_gt_test.sv
module precomp_gt_test;
    localparam int CLK_PERIOD = 10;
    localparam int CW = 16;
    localparam int NV = 16;

    localparam logic [7:0] VA [NV] = '{8'h80, 8'h7F, 8'h55, 8'h56, 8'hC0, 8'hFF, 8'h00, 8'h80,
                                       8'h01, 8'h90, 8'h12, 8'hFF, 8'h00, 8'h81, 8'h7E, 8'hF0};
    localparam logic [7:0] VB [NV] = '{8'h7F, 8'h80, 8'h55, 8'h55, 8'hBF, 8'hFE, 8'h01, 8'hFF,
                                       8'hFF, 8'h10, 8'h11, 8'hFF, 8'h00, 8'h80, 8'h7F, 8'h0F};

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [7:0]    a8 = '0, b8 = '0;
    logic [1:0]    a2 = '0, b2 = '0;
    logic          f8, f2;
    logic [CW-1:0] cnt8, cnt2;

    int checks = 0;
    int errors = 0;
    logic e8_h1 = 1'b0, e8_h2 = 1'b0, e2_h1 = 1'b0, e2_h2 = 1'b0;
    int ex8 = 0, ex2 = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    precomp_gt #(.WIDTH(8), .CNT_W(CW)) uut (
        .clk(clk), .rst(rst), .a_in(a8), .b_in(b8), .a_gt_b(f8), .skip_count(cnt8));

    precomp_gt #(.WIDTH(2), .CNT_W(CW)) uut2 (
        .clk(clk), .rst(rst), .a_in(a2), .b_in(b2), .a_gt_b(f2), .skip_count(cnt2));

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // Check outputs for pairs driven two negedges ago, then drive a new pair.
    task automatic apply(input logic [7:0] na, input logic [7:0] nb,
                         input logic [1:0] ma, input logic [1:0] mb, input string req);
        @(negedge clk);
        chk(req, "w8 result", int'(f8), int'(e8_h2));
        chk(req, "w2 result", int'(f2), int'(e2_h2));
        chk("R6", "w8 skip count", int'(cnt8), ex8);
        chk("R6", "w2 skip count", int'(cnt2), ex2);
        e8_h2 = e8_h1; e8_h1 = (na > nb);
        e2_h2 = e2_h1; e2_h1 = (ma > mb);
        a8 = na; b8 = nb; a2 = ma; b2 = mb;
        if (na[7] != nb[7]) ex8++;
        if (ma[1] != mb[1]) ex2++;
    endtask

    task automatic do_reset(input logic [7:0] ra, input logic [7:0] rb);
        @(negedge clk);
        rst = 1'b1;
        a8 = ra; b8 = rb; a2 = ra[1:0] ^ 2'b10; b2 = rb[1:0];
        @(negedge clk);
        @(negedge clk);
        chk("R7", "w8 result in reset", int'(f8), 0);
        chk("R7", "w8 count in reset", int'(cnt8), 0);
        chk("R7", "w2 result in reset", int'(f2), 0);
        chk("R7", "w2 count in reset", int'(cnt2), 0);
        rst = 1'b0;
        a8 = '0; b8 = '0; a2 = '0; b2 = '0;
        e8_h1 = 1'b0; e8_h2 = 1'b0; e2_h1 = 1'b0; e2_h2 = 1'b0;
        ex8 = 0; ex2 = 0;
    endtask

    initial begin
        // R7: reset held while top bits differ
        do_reset(8'h80, 8'h00);

        // R1 R2 R3 R4: table of mixed patterns
        for (int i = 0; i < NV; i++) begin
            apply(VA[i], VB[i], 2'b00, 2'b00, "R1/R3/R4");
        end
        apply(8'h00, 8'h00, 2'b00, 2'b00, "R1");
        apply(8'h00, 8'h00, 2'b00, 2'b00, "R1");

        // R5 R3: load lower bits, then freeze them under differing top bits
        apply(8'h33, 8'h22, 2'b00, 2'b00, "R5");
        apply(8'h80, 8'h7F, 2'b00, 2'b00, "R3");
        apply(8'h00, 8'hFF, 2'b00, 2'b00, "R3");
        apply(8'h80, 8'h00, 2'b00, 2'b00, "R2");
        // R4: lower bits reload after freeze and break the tie
        apply(8'hA5, 8'hA4, 2'b00, 2'b00, "R4");
        apply(8'h5A, 8'h5B, 2'b00, 2'b00, "R4");
        apply(8'h00, 8'h00, 2'b00, 2'b00, "R4");
        apply(8'h00, 8'h00, 2'b00, 2'b00, "R4");

        // R7: mid-stream reset
        apply(8'hF0, 8'h0F, 2'b00, 2'b00, "R1");
        do_reset(8'h00, 8'hFF);

        // R8: exhaustive at minimum width
        for (int x = 0; x < 4; x++) begin
            for (int y = 0; y < 4; y++) begin
                apply(8'h00, 8'h00, 2'(x), 2'(y), "R8");
            end
        end
        apply(8'h00, 8'h00, 2'b00, 2'b00, "R8");
        apply(8'h00, 8'h00, 2'b00, 2'b00, "R8");

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule